// File: doc/BRIEF.md
# RTC Interrupt Emulation Engine

This block recreates the three interrupt sources of a real-time clock (once-per-second update, time-of-day alarm and a periodic rate) from a single compare channel that runs against a free-running timebase count. A base interval, expressed in timebase cycles, sets the default 64 Hz polling rate. The update and alarm sources are checked once per polling tick. The periodic source is either a divided version of that tick or, for rates above 64 Hz, a shortened tick interval.

Each tick service moves the compare point forward by one interval. It keeps doing so until the compare point is ahead of the timebase again, and counts every extra step as a lost tick. Lost ticks are credited to the periodic divider, so a stalled timebase does not slow the periodic rate. When a service raises at least one source flag, the block emits a one-cycle interrupt pulse together with a flag word.

The result side behaves like a stream with valid and no ready. `irq_o` is the valid strobe and cannot be back-pressured. `flags_o` holds its value until the next tick service rewrites it, so a consumer has at least one full tick interval to read it. All configuration pins are plain levels.

Top module: `rtc_emu_engine`

## Requirements
- R1: After reset, `irq_o` is 0, `flags_o` is 0, `lost_o` is 0 and `chan_en_o` is 0.
- R2: When at least one source enable is high after a cycle with none high, the next cycle shows `chan_en_o` = 1 and `cmp_o` = the sampled `now_i` plus the current interval. Raising another enable while one is already high leaves `cmp_o` unchanged.
- R3: When all three source enables are low, `chan_en_o` is 0 from the next cycle on, and `irq_o` stays 0 for as long as they remain low.
- R4: The tick interval is `base_ival_i` when the periodic source is off or `rate_code_i` is 6 or less. Rate code k means 2^k Hz, for k from 1 to 13. For k above 6 with the periodic source on, the interval is `base_ival_i` shifted right by k-6. With the timebase advancing one count per cycle, successive ticks are exactly one interval apart.
- R5: The update flag, at bit 4, is raised on a tick when the update source is enabled and `sec_i` differs from the seconds value stored at the last update. That value is then stored; it is 0 after reset.
- R6: The alarm flag, at bit 5, is raised on a tick when the alarm source is enabled and hours, minutes and seconds all equal the alarm inputs. A mismatch in any field gives no alarm.
- R7: For rate code k of 6 or less, the periodic flag (bit 6) is raised every 2^(6-k) ticks, and the divider count then returns to 0. While the periodic source is off, the divider count is held at 0.
- R8: When any flag is raised, `flags_o` also has bit 7 set and 1 in bits 15:8. `irq_o` is high for exactly one cycle. `flags_o` holds until the next tick service.
- R9: A service steps `cmp_o` by one interval per cycle until `now_i` is no longer past it. `lost_o` reports the number of steps beyond the first. While the periodic source is on, that number is added to the divider count along with the current tick.
- R10: A tick service that raises no flag produces no `irq_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_i | input | CW | Free-running timebase count |
| base_ival_i | input | CW | Timebase cycles per 64 Hz tick |
| upd_en_i | input | 1 | Update source enable |
| alm_en_i | input | 1 | Alarm source enable |
| per_en_i | input | 1 | Periodic source enable |
| rate_code_i | input | RW | Periodic rate as log2 of Hz |
| hour_i | input | TW | Current hours |
| min_i | input | TW | Current minutes |
| sec_i | input | TW | Current seconds |
| alm_hour_i | input | TW | Alarm hours |
| alm_min_i | input | TW | Alarm minutes |
| alm_sec_i | input | TW | Alarm seconds |
| irq_o | output | 1 | One-cycle interrupt strobe |
| flags_o | output | 16 | Source flag word |
| lost_o | output | LW | Lost ticks at the last service (saturating) |
| chan_en_o | output | 1 | Compare channel armed |
| cmp_o | output | CW | Current compare point |

## Verification
The update, alarm and periodic sources can all fire on the same tick service, and they must merge into one pulse rather than separate events. The bench provokes this by enabling all three sources with the time equal to the alarm and with a seconds value that differs from the stored one. It then judges the single pulse by requiring the exact word 16'h01F0. A lost-tick service that coincides with a periodic divider count is also forced, by jumping the timebase past two intervals. The bench then checks both the lost count and the early arrival of the periodic flag that the credit causes.

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;
  localparam int FLG_UPD  = 4;
  localparam int FLG_ALM  = 5;
  localparam int FLG_PER  = 6;
  localparam int FLG_PEND = 7;
  localparam int CNT_LSB  = 8;
  localparam int FLAG_W   = 16;

  typedef enum logic {
    S_WAIT = 1'b0,
    S_ADV  = 1'b1
  } sched_e;
endpackage

// File: rtl/rtc_emu_ival.sv
module rtc_emu_ival #(
  parameter int CW        = 32,
  parameter int RW        = 4,
  parameter int BASE_LOG2 = 6,
  localparam int DW       = BASE_LOG2 + 1
) (
  input  logic [CW-1:0] base_ival,
  input  logic          per_en,
  input  logic [RW-1:0] rate_code,
  output logic [CW-1:0] ival,
  output logic [DW-1:0] div_limit
);
  localparam logic [RW-1:0] BASE_C = RW'(BASE_LOG2);

  logic [CW-1:0] shifted;

  always_comb begin
    shifted = base_ival >> (rate_code - BASE_C);
    if (per_en && (rate_code > BASE_C)) begin
      ival = (shifted == '0) ? CW'(1) : shifted;
    end else begin
      ival = base_ival;
    end
    if (rate_code <= BASE_C) begin
      div_limit = DW'(1) << (BASE_C - rate_code);
    end else begin
      div_limit = DW'(1);
    end
  end
endmodule

// File: rtl/rtc_emu_sched.sv
module rtc_emu_sched
  import rtc_emu_pkg::*;
#(
  parameter int CW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] now_i,
  input  logic [CW-1:0] ival,
  input  logic          any_en,
  output logic [CW-1:0] cmp_o,
  output logic          chan_en_o,
  output logic          svc_done,
  output logic [LW-1:0] lost_now
);
  sched_e        state_q;
  logic [CW-1:0] cmp_q;
  logic          chan_q;
  logic          any_q;
  logic [LW-1:0] adv_q;
  logic [CW-1:0] nxt;
  logic [CW-1:0] d_cur;
  logic [CW-1:0] d_nxt;
  logic          due;
  logic          behind;

  always_comb begin
    nxt    = cmp_q + ival;
    d_cur  = now_i - cmp_q;
    d_nxt  = now_i - nxt;
    due    = !d_cur[CW-1];
    behind = !d_nxt[CW-1] && (d_nxt != '0);
  end

  assign svc_done  = (state_q == S_ADV) && any_en && any_q && !behind;
  assign lost_now  = adv_q;
  assign cmp_o     = cmp_q;
  assign chan_en_o = chan_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_WAIT;
      cmp_q   <= '0;
      chan_q  <= 1'b0;
      any_q   <= 1'b0;
      adv_q   <= '0;
    end else begin
      any_q <= any_en;
      if (!any_en) begin
        chan_q  <= 1'b0;
        state_q <= S_WAIT;
      end else if (!any_q) begin
        cmp_q   <= now_i + ival;
        chan_q  <= 1'b1;
        state_q <= S_WAIT;
      end else begin
        unique case (state_q)
          S_WAIT: begin
            if (chan_q && due) begin
              state_q <= S_ADV;
              adv_q   <= '0;
            end
          end
          S_ADV: begin
            cmp_q <= nxt;
            if (behind) begin
              if (adv_q != '1) adv_q <= adv_q + LW'(1);
            end else begin
              state_q <= S_WAIT;
            end
          end
          default: state_q <= S_WAIT;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_emu_flags.sv
module rtc_emu_flags
  import rtc_emu_pkg::*;
#(
  parameter int TW = 6,
  parameter int LW = 8,
  parameter int DW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc_done,
  input  logic [LW-1:0]     lost_now,
  input  logic              upd_en,
  input  logic              alm_en,
  input  logic              per_en,
  input  logic [DW-1:0]     div_limit,
  input  logic [TW-1:0]     hour_i,
  input  logic [TW-1:0]     min_i,
  input  logic [TW-1:0]     sec_i,
  input  logic [TW-1:0]     alm_hour_i,
  input  logic [TW-1:0]     alm_min_i,
  input  logic [TW-1:0]     alm_sec_i,
  output logic              irq_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [LW-1:0]     lost_o
);
  localparam int SW = LW + DW;

  logic [TW-1:0]     last_sec_q;
  logic [DW-1:0]     pcnt_q;
  logic [SW-1:0]     psum;
  logic              uf;
  logic              af;
  logic              pf;
  logic [FLAG_W-1:0] word;

  always_comb begin
    uf   = upd_en && (sec_i != last_sec_q);
    af   = alm_en && (hour_i == alm_hour_i) && (min_i == alm_min_i)
           && (sec_i == alm_sec_i);
    psum = SW'(pcnt_q) + SW'(lost_now) + SW'(1);
    pf   = per_en && (psum >= SW'(div_limit));
    word = '0;
    word[FLG_UPD] = uf;
    word[FLG_ALM] = af;
    word[FLG_PER] = pf;
    if (uf || af || pf) begin
      word[FLG_PEND] = 1'b1;
      word[FLAG_W-1:CNT_LSB] = (FLAG_W - CNT_LSB)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_sec_q <= '0;
      pcnt_q     <= '0;
      irq_o      <= 1'b0;
      flags_o    <= '0;
      lost_o     <= '0;
    end else begin
      irq_o <= 1'b0;
      if (!per_en) pcnt_q <= '0;
      if (svc_done) begin
        if (uf) last_sec_q <= sec_i;
        if (per_en) pcnt_q <= pf ? '0 : psum[DW-1:0];
        flags_o <= word;
        irq_o   <= uf || af || pf;
        lost_o  <= lost_now;
      end
    end
  end
endmodule

// File: rtl/rtc_emu_engine.sv
module rtc_emu_engine
  import rtc_emu_pkg::*;
#(
  parameter int CW        = 32,
  parameter int TW        = 6,
  parameter int RW        = 4,
  parameter int LW        = 8,
  parameter int BASE_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     now_i,
  input  logic [CW-1:0]     base_ival_i,
  input  logic              upd_en_i,
  input  logic              alm_en_i,
  input  logic              per_en_i,
  input  logic [RW-1:0]     rate_code_i,
  input  logic [TW-1:0]     hour_i,
  input  logic [TW-1:0]     min_i,
  input  logic [TW-1:0]     sec_i,
  input  logic [TW-1:0]     alm_hour_i,
  input  logic [TW-1:0]     alm_min_i,
  input  logic [TW-1:0]     alm_sec_i,
  output logic              irq_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [LW-1:0]     lost_o,
  output logic              chan_en_o,
  output logic [CW-1:0]     cmp_o
);
  localparam int DW = BASE_LOG2 + 1;

  logic [CW-1:0] ival;
  logic [DW-1:0] div_limit;
  logic          any_en;
  logic          svc_done;
  logic [LW-1:0] lost_now;

  assign any_en = upd_en_i || alm_en_i || per_en_i;

  rtc_emu_ival #(.CW(CW), .RW(RW), .BASE_LOG2(BASE_LOG2)) u_ival (
    .base_ival (base_ival_i),
    .per_en    (per_en_i),
    .rate_code (rate_code_i),
    .ival      (ival),
    .div_limit (div_limit)
  );

  rtc_emu_sched #(.CW(CW), .LW(LW)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .now_i     (now_i),
    .ival      (ival),
    .any_en    (any_en),
    .cmp_o     (cmp_o),
    .chan_en_o (chan_en_o),
    .svc_done  (svc_done),
    .lost_now  (lost_now)
  );

  rtc_emu_flags #(.TW(TW), .LW(LW), .DW(DW)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .svc_done   (svc_done),
    .lost_now   (lost_now),
    .upd_en     (upd_en_i),
    .alm_en     (alm_en_i),
    .per_en     (per_en_i),
    .div_limit  (div_limit),
    .hour_i     (hour_i),
    .min_i      (min_i),
    .sec_i      (sec_i),
    .alm_hour_i (alm_hour_i),
    .alm_min_i  (alm_min_i),
    .alm_sec_i  (alm_sec_i),
    .irq_o      (irq_o),
    .flags_o    (flags_o),
    .lost_o     (lost_o)
  );
endmodule

// File: rtl/rtc_emu_engine_chk.sv
module rtc_emu_engine_chk #(
  parameter int TW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          upd_en_i,
  input logic          alm_en_i,
  input logic          per_en_i,
  input logic [TW-1:0] hour_i,
  input logic [TW-1:0] min_i,
  input logic [TW-1:0] sec_i,
  input logic [TW-1:0] alm_hour_i,
  input logic [TW-1:0] alm_min_i,
  input logic [TW-1:0] alm_sec_i,
  input logic          irq_o,
  input logic [15:0]   flags_o,
  input logic          chan_en_o
);
  logic any_en;
  logic time_eq;
  assign any_en  = upd_en_i || alm_en_i || per_en_i;
  assign time_eq = (hour_i == alm_hour_i) && (min_i == alm_min_i) && (sec_i == alm_sec_i);

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R8
  irq_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flags_o[7] && (flags_o[15:8] == 8'd1)));

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flags_o[6:4] != 3'b000));

  // R3
  chan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_en |=> !chan_en_o);

  // R3
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_en && !$past(any_en)) |-> !irq_o);

  // R6
  alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && flags_o[5]) |-> ($past(alm_en_i) && $past(time_eq)));

  // R2
  arm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_en_o) |-> $past(any_en));
endmodule

bind rtc_emu_engine rtc_emu_engine_chk #(.TW(TW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_en_i   (upd_en_i),
  .alm_en_i   (alm_en_i),
  .per_en_i   (per_en_i),
  .hour_i     (hour_i),
  .min_i      (min_i),
  .sec_i      (sec_i),
  .alm_hour_i (alm_hour_i),
  .alm_min_i  (alm_min_i),
  .alm_sec_i  (alm_sec_i),
  .irq_o      (irq_o),
  .flags_o    (flags_o),
  .chan_en_o  (chan_en_o)
);

// File: tb/tb_rtc_emu_engine.sv
`timescale 1ns/1ps
module tb_rtc_emu_engine;
  localparam int CW   = 32;
  localparam int BASE = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] tb_now;
  logic          jump_en = 1'b0;
  logic [CW-1:0] jump_val = '0;
  logic          upd_en = 0, alm_en = 0, per_en = 0;
  logic [3:0]    rate_code = 4'd6;
  logic [5:0]    hour = 0, minute = 0, sec = 0;
  logic [5:0]    a_hour = 0, a_min = 0, a_sec = 0;
  logic          irq_o;
  logic [15:0]   flags_o;
  logic [7:0]    lost_o;
  logic          chan_en_o;
  logic [CW-1:0] cmp_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) tb_now <= 32'd1000;
    else        tb_now <= jump_en ? jump_val : tb_now + 32'd1;
  end

  rtc_emu_engine dut (
    .clk(clk), .rst_n(rst_n), .now_i(tb_now), .base_ival_i(CW'(BASE)),
    .upd_en_i(upd_en), .alm_en_i(alm_en), .per_en_i(per_en),
    .rate_code_i(rate_code), .hour_i(hour), .min_i(minute), .sec_i(sec),
    .alm_hour_i(a_hour), .alm_min_i(a_min), .alm_sec_i(a_sec),
    .irq_o(irq_o), .flags_o(flags_o), .lost_o(lost_o),
    .chan_en_o(chan_en_o), .cmp_o(cmp_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_irq(input int maxc, output bit got, output int n);
    got = 0;
    n = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      n++;
      if (irq_o) begin
        got = 1;
        break;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    upd_en = 0; alm_en = 0; per_en = 0; rate_code = 4'd6;
    hour = 0; minute = 0; sec = 0; a_hour = 0; a_min = 0; a_sec = 0;
    jump_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(irq_o == 0 && flags_o == 0, "R1 irq/flags", {irq_o, flags_o}, 0);
    chk(lost_o == 0 && chan_en_o == 0, "R1 lost/chan", {lost_o, chan_en_o}, 0);
  endtask

  task automatic t_update();
    bit got; int n; logic [CW-1:0] base_now, c;
    do_reset();
    sec = 6'd5;
    base_now = tb_now;
    upd_en = 1;
    @(negedge clk);
    chk(chan_en_o == 1, "R2 armed", chan_en_o, 1);
    chk(cmp_o == base_now + BASE, "R2 arm point", cmp_o, base_now + BASE);
    wait_irq(BASE + 10, got, n);
    chk(got, "R5 first update irq", got, 1);
    chk(flags_o == 16'h0190, "R5 update word", flags_o, 16'h0190);
    c = cmp_o;
    alm_en = 1;
    @(negedge clk);
    chk(irq_o == 0, "R8 single-cycle pulse", irq_o, 0);
    chk(cmp_o == c, "R2 no re-arm while armed", cmp_o, c);
    alm_en = 0;
    repeat (10) @(negedge clk);
    chk(flags_o == 16'h0190, "R8 word held", flags_o, 16'h0190);
    wait_irq(2 * BASE + 12, got, n);
    chk(!got, "R10 unchanged seconds gives no irq", got, 0);
    sec = 6'd6;
    wait_irq(BASE + 16, got, n);
    chk(got && flags_o == 16'h0190, "R5 new seconds irq", flags_o, 16'h0190);
  endtask

  task automatic t_alarm();
    bit got; int n;
    do_reset();
    hour = 3; minute = 4; sec = 0; a_hour = 3; a_min = 4; a_sec = 0;
    alm_en = 1;
    wait_irq(BASE + 10, got, n);
    chk(got && flags_o == 16'h01A0, "R6 alarm word", flags_o, 16'h01A0);
    wait_irq(BASE + 10, got, n);
    chk(got && n == BASE, "R4 default interval", n, BASE);
    a_min = 7;
    wait_irq(2 * BASE + 12, got, n);
    chk(!got, "R6 minute mismatch no alarm", got, 0);
  endtask

  task automatic t_periodic();
    bit got; int n;
    do_reset();
    rate_code = 4'd4;
    per_en = 1;
    wait_irq(4 * BASE + 10, got, n);
    chk(got && flags_o == 16'h01C0, "R7 periodic word", flags_o, 16'h01C0);
    wait_irq(5 * BASE, got, n);
    chk(got && n == 4 * BASE, "R7 divide by four", n, 4 * BASE);
    do_reset();
    rate_code = 4'd8;
    per_en = 1;
    wait_irq(BASE + 10, got, n);
    wait_irq(BASE, got, n);
    chk(got && n == BASE / 4, "R4 shortened interval", n, BASE / 4);
  endtask

  task automatic t_lost();
    bit got; int n; bit early;
    do_reset();
    rate_code = 4'd4;
    per_en = 1;
    wait_irq(4 * BASE + 10, got, n);
    jump_val = cmp_o + 2 * BASE + 5;
    jump_en = 1;
    @(negedge clk);
    jump_en = 0;
    early = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (irq_o) early = 1;
    end
    chk(lost_o == 8'd2, "R9 lost count", lost_o, 2);
    chk(!early, "R9 no flag on lost service", early, 0);
    wait_irq(BASE + 10, got, n);
    chk(got && flags_o == 16'h01C0, "R9 lost credited to divider", n, BASE);
  endtask

  task automatic t_disable();
    bit got; int n;
    do_reset();
    upd_en = 1;
    wait_irq(BASE + 10, got, n);
    upd_en = 0;
    @(negedge clk);
    @(negedge clk);
    chk(chan_en_o == 0, "R3 channel off", chan_en_o, 0);
    sec = 6'd30;
    wait_irq(3 * BASE, got, n);
    chk(!got, "R3 no irq while all off", got, 0);
  endtask

  task automatic t_concurrent();
    bit got; int n;
    do_reset();
    hour = 1; minute = 2; sec = 9; a_hour = 1; a_min = 2; a_sec = 9;
    rate_code = 4'd6;
    upd_en = 1; alm_en = 1; per_en = 1;
    wait_irq(BASE + 10, got, n);
    chk(got && flags_o == 16'h01F0, "R5 R6 R7 same-tick merge", flags_o, 16'h01F0);
    @(negedge clk);
    chk(irq_o == 0, "R8 merged single pulse", irq_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_update();
    t_alarm();
    t_periodic();
    t_lost();
    t_disable();
    t_concurrent();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule